// File: doc/BRIEF.md
# Radar Host Command Register Decoder

This block sits between the host command path and the radar's runtime configuration. Each command is an 8-bit opcode and a 16-bit value, qualified by a one-cycle valid strobe. The decoder selects the configuration register that the opcode names and loads it on the clock edge that samples the strobe. The registers hold the chirp and listen lengths for the short and medium pulse modes, an unsigned Q4.4 scale factor for the soft detection threshold, the converter power-down pin and the converter sample-format select.

Chirps per elevation has exactly one legal count, 48. The value passed to the datapath never leaves 48. A request for any other count raises a sticky error flag, and only reset clears that flag. An opcode the block does not know changes no register and produces a one-cycle pulse. The host reads configuration back through a word-select input that picks one of seven 32-bit status words. Medium-mode timing has no room in these words and is not reported.

Top module: `radar_cmd_decoder`

## Requirements
- R1: After reset: short chirp 100, short listen 17400, medium chirp 500, medium listen 15600, threshold scale 0x18, power-down 0, format 0, chirps per elevation 48, mismatch error 0, unknown pulse 0.
- R2: With valid high, opcodes 0x10 (short chirp), 0x11 (short listen), 0x17 (medium chirp) and 0x18 (medium listen) load the full 16-bit value. The new value shows on the output after that clock edge.
- R3: With valid high, opcode 0x2D loads value bits [7:0] into the threshold scale. Bits [15:8] are ignored.
- R4: With valid high, opcode 0x32 sets the power-down pin to value bit 0 (1 = powered down). All other value bits are ignored.
- R5: With valid high, opcode 0x33 sets the format select to value bit 0 (0 = offset binary, 1 = two's complement). All other value bits are ignored.
- R6: Opcode 0x21 records the requested chirps-per-elevation count. The chirps-per-elevation output stays 48 whatever value is written.
- R7: A 0x21 write of any value other than 48 sets the mismatch error on the next edge. A later write of 48 does not clear it; only reset does.
- R8: An opcode outside {0x10, 0x11, 0x17, 0x18, 0x21, 0x2D, 0x32, 0x33} with valid high changes no register. It raises unknown_opcode for exactly one cycle after the edge.
- R9: While valid is low, no register changes and unknown_opcode stays low, whatever the opcode and value are.
- R10: The status word selected by status_sel is laid out as follows. Word 0 is {short chirp, short listen}. Word 1 has the threshold scale in [31:24], format in bit 1 and power-down in bit 0. Word 2 has the requested chirps-per-elevation count in [15:0]. Word 4 has the mismatch error in bit 10 and the effective chirps-per-elevation count in [7:0]. Words 3, 5 and 6 and any select of 7 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_opcode | input | 8 | Command opcode |
| cmd_value | input | 16 | Command value |
| status_sel | input | 3 | Status word select |
| status_word | output | 32 | Selected status word |
| short_chirp_cycles | output | 16 | Short-mode chirp length in cycles |
| short_listen_cycles | output | 16 | Short-mode listen length in cycles |
| medium_chirp_cycles | output | 16 | Medium-mode chirp length in cycles |
| medium_listen_cycles | output | 16 | Medium-mode listen length in cycles |
| thresh_scale | output | 8 | Soft threshold scale, unsigned Q4.4 |
| adc_powerdown | output | 1 | Converter power-down pin |
| adc_twos_comp | output | 1 | Converter sample format select |
| chirps_per_elev | output | 8 | Effective chirps per elevation |
| chirp_count_err | output | 1 | Sticky chirps-per-elevation mismatch |
| unknown_opcode | output | 1 | One-cycle pulse for an unrecognised opcode |

## Verification
The assertions assume that cmd_valid, cmd_opcode and cmd_value are stable around each rising edge. They also assume that a command lasts exactly one sampled cycle, so the previous cycle's value is the one that was loaded. They assume status_sel is a settled select and not a value that changes within a cycle. The stimulus changes every input only on the falling edge and drops valid after one cycle. It also applies opcode and value changes while valid is low, so the R9 quiet-hold checks see real activity on the inputs.

// File: rtl/rcd_pkg.sv
package rcd_pkg;

  localparam int OPC_W    = 8;
  localparam int VAL_W    = 16;
  localparam int STAT_W   = 32;
  localparam int N_STATUS = 7;
  localparam int SEL_W    = $clog2(N_STATUS + 1);
  localparam int CPE_W    = 8;
  localparam int N_TIMING = 4;
  localparam int N_TGT    = 8;

  localparam logic [VAL_W-1:0] CPE_LEGAL     = 16'd48;
  localparam logic [7:0]       THRESH_RESET  = 8'h18;

  typedef enum logic [OPC_W-1:0] {
    OP_SHORT_CHIRP  = 8'h10,
    OP_SHORT_LISTEN = 8'h11,
    OP_MED_CHIRP    = 8'h17,
    OP_MED_LISTEN   = 8'h18,
    OP_CPE          = 8'h21,
    OP_THRESH       = 8'h2D,
    OP_ADC_PD       = 8'h32,
    OP_ADC_FMT      = 8'h33
  } opcode_e;

  // Write-target index; timing registers occupy 0..3 in this order.
  localparam int TGT_SHORT_CHIRP  = 0;
  localparam int TGT_SHORT_LISTEN = 1;
  localparam int TGT_MED_CHIRP    = 2;
  localparam int TGT_MED_LISTEN   = 3;
  localparam int TGT_THRESH       = 4;
  localparam int TGT_ADC_PD       = 5;
  localparam int TGT_ADC_FMT      = 6;
  localparam int TGT_CPE          = 7;

  function automatic logic [VAL_W-1:0] timing_default(input int idx);
    case (idx)
      TGT_SHORT_CHIRP:  return 16'd100;
      TGT_SHORT_LISTEN: return 16'd17400;
      TGT_MED_CHIRP:    return 16'd500;
      default:          return 16'd15600;
    endcase
  endfunction

  function automatic logic cpe_mismatch(input logic [VAL_W-1:0] v);
    return v != CPE_LEGAL;
  endfunction

endpackage

// File: rtl/rcd_opcode_decode.sv
module rcd_opcode_decode
  import rcd_pkg::*;
(
  input  logic                 valid,
  input  logic [OPC_W-1:0]     opcode,
  output logic [N_TGT-1:0]     wr_en,
  output logic                 unknown_hit
);

  logic [N_TGT-1:0] hit;

  always_comb begin
    hit = '0;
    case (opcode)
      OP_SHORT_CHIRP:  hit[TGT_SHORT_CHIRP]  = 1'b1;
      OP_SHORT_LISTEN: hit[TGT_SHORT_LISTEN] = 1'b1;
      OP_MED_CHIRP:    hit[TGT_MED_CHIRP]    = 1'b1;
      OP_MED_LISTEN:   hit[TGT_MED_LISTEN]   = 1'b1;
      OP_THRESH:       hit[TGT_THRESH]       = 1'b1;
      OP_ADC_PD:       hit[TGT_ADC_PD]       = 1'b1;
      OP_ADC_FMT:      hit[TGT_ADC_FMT]      = 1'b1;
      OP_CPE:          hit[TGT_CPE]          = 1'b1;
      default:         hit = '0;
    endcase
  end

  assign wr_en       = valid ? hit : '0;
  assign unknown_hit = valid && (hit == '0);

endmodule

// File: rtl/rcd_cfg_reg.sv
module rcd_cfg_reg #(
  parameter int           W   = 16,
  parameter logic [W-1:0] RST = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  always_ff @(posedge clk) begin
    if (!rst_n)  q <= RST;
    else if (en) q <= d;
  end

endmodule

// File: rtl/rcd_status_mux.sv
module rcd_status_mux
  import rcd_pkg::*;
(
  input  logic [SEL_W-1:0]  sel,
  input  logic [VAL_W-1:0]  short_chirp,
  input  logic [VAL_W-1:0]  short_listen,
  input  logic [7:0]        thresh,
  input  logic              pd,
  input  logic              fmt,
  input  logic [VAL_W-1:0]  cpe_req,
  input  logic [CPE_W-1:0]  cpe_eff,
  input  logic              err,
  output logic [STAT_W-1:0] word
);

  always_comb begin
    word = '0;
    case (sel)
      3'd0: word = {short_chirp, short_listen};
      3'd1: word = {thresh, 22'd0, fmt, pd};
      3'd2: word = {16'd0, cpe_req};
      3'd4: word = {21'd0, err, 2'd0, cpe_eff};
      default: word = '0;
    endcase
  end

endmodule

// File: rtl/radar_cmd_decoder.sv
module radar_cmd_decoder
  import rcd_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cmd_valid,
  input  logic [OPC_W-1:0]     cmd_opcode,
  input  logic [VAL_W-1:0]     cmd_value,
  input  logic [SEL_W-1:0]     status_sel,
  output logic [STAT_W-1:0]    status_word,
  output logic [VAL_W-1:0]     short_chirp_cycles,
  output logic [VAL_W-1:0]     short_listen_cycles,
  output logic [VAL_W-1:0]     medium_chirp_cycles,
  output logic [VAL_W-1:0]     medium_listen_cycles,
  output logic [7:0]           thresh_scale,
  output logic                 adc_powerdown,
  output logic                 adc_twos_comp,
  output logic [CPE_W-1:0]     chirps_per_elev,
  output logic                 chirp_count_err,
  output logic                 unknown_opcode
);

  // Named internal events, observed by the bound checker.
  logic [N_TGT-1:0]    wr_en;
  logic                unknown_hit;
  logic                cpe_bad_write;
  logic [VAL_W-1:0]    timing_q [N_TIMING];
  logic [VAL_W-1:0]    cpe_req_q;
  logic                err_q;
  logic                unk_q;

  rcd_opcode_decode u_dec (
    .valid       (cmd_valid),
    .opcode      (cmd_opcode),
    .wr_en       (wr_en),
    .unknown_hit (unknown_hit)
  );

  for (genvar i = 0; i < N_TIMING; i++) begin : g_timing
    rcd_cfg_reg #(.W(VAL_W), .RST(timing_default(i))) u_reg (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (wr_en[i]),
      .d     (cmd_value),
      .q     (timing_q[i])
    );
  end

  rcd_cfg_reg #(.W(8), .RST(THRESH_RESET)) u_thresh (
    .clk (clk), .rst_n (rst_n), .en (wr_en[TGT_THRESH]),
    .d (cmd_value[7:0]), .q (thresh_scale)
  );

  rcd_cfg_reg #(.W(1), .RST(1'b0)) u_pd (
    .clk (clk), .rst_n (rst_n), .en (wr_en[TGT_ADC_PD]),
    .d (cmd_value[0]), .q (adc_powerdown)
  );

  rcd_cfg_reg #(.W(1), .RST(1'b0)) u_fmt (
    .clk (clk), .rst_n (rst_n), .en (wr_en[TGT_ADC_FMT]),
    .d (cmd_value[0]), .q (adc_twos_comp)
  );

  rcd_cfg_reg #(.W(VAL_W), .RST(CPE_LEGAL)) u_cpe_req (
    .clk (clk), .rst_n (rst_n), .en (wr_en[TGT_CPE]),
    .d (cmd_value), .q (cpe_req_q)
  );

  assign cpe_bad_write = wr_en[TGT_CPE] && cpe_mismatch(cmd_value);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_q <= 1'b0;
      unk_q <= 1'b0;
    end else begin
      err_q <= err_q | cpe_bad_write;
      unk_q <= unknown_hit;
    end
  end

  assign short_chirp_cycles   = timing_q[TGT_SHORT_CHIRP];
  assign short_listen_cycles  = timing_q[TGT_SHORT_LISTEN];
  assign medium_chirp_cycles  = timing_q[TGT_MED_CHIRP];
  assign medium_listen_cycles = timing_q[TGT_MED_LISTEN];
  assign chirps_per_elev      = CPE_LEGAL[CPE_W-1:0];
  assign chirp_count_err      = err_q;
  assign unknown_opcode       = unk_q;

  rcd_status_mux u_stat (
    .sel          (status_sel),
    .short_chirp  (short_chirp_cycles),
    .short_listen (short_listen_cycles),
    .thresh       (thresh_scale),
    .pd           (adc_powerdown),
    .fmt          (adc_twos_comp),
    .cpe_req      (cpe_req_q),
    .cpe_eff      (chirps_per_elev),
    .err          (err_q),
    .word         (status_word)
  );

endmodule

// File: rtl/rcd_checker.sv
module rcd_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        cmd_valid,
  input logic [7:0]  cmd_opcode,
  input logic [15:0] cmd_value,
  input logic [2:0]  status_sel,
  input logic [31:0] status_word,
  input logic [15:0] short_chirp_cycles,
  input logic [15:0] medium_chirp_cycles,
  input logic [7:0]  thresh_scale,
  input logic        adc_powerdown,
  input logic        adc_twos_comp,
  input logic        chirp_count_err,
  input logic        unknown_opcode,
  input logic [7:0]  wr_en
);

  function automatic logic listed(input logic [7:0] op);
    return op == 8'h10 || op == 8'h11 || op == 8'h17 || op == 8'h18 ||
           op == 8'h21 || op == 8'h2D || op == 8'h32 || op == 8'h33;
  endfunction

  assert_med_chirp_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_opcode == 8'h17) |=> medium_chirp_cycles == $past(cmd_value));

  assert_thresh_low_byte_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_opcode == 8'h2D) |=> thresh_scale == $past(cmd_value[7:0]));

  assert_pd_bit0_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_opcode == 8'h32) |=> adc_powerdown == $past(cmd_value[0]));

  assert_fmt_bit0_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_opcode == 8'h33) |=> adc_twos_comp == $past(cmd_value[0]));

  assert_err_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_opcode == 8'h21 && cmd_value != 16'd48) |=> chirp_count_err);

  assert_err_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    chirp_count_err |=> chirp_count_err);

  assert_unknown_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !listed(cmd_opcode)) |=>
      unknown_opcode && $stable(short_chirp_cycles) && $stable(thresh_scale) &&
      $stable(adc_powerdown) && $stable(adc_twos_comp));

  assert_single_target_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_en));

  assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |=> !unknown_opcode && $stable(short_chirp_cycles) &&
      $stable(medium_chirp_cycles) && $stable(thresh_scale) &&
      $stable(adc_powerdown) && $stable(adc_twos_comp) && $stable(chirp_count_err));

  assert_status_err_bit_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (status_sel == 3'd4) |-> status_word[10] == chirp_count_err);

endmodule

bind radar_cmd_decoder rcd_checker chk_i (
  .clk                 (clk),
  .rst_n               (rst_n),
  .cmd_valid           (cmd_valid),
  .cmd_opcode          (cmd_opcode),
  .cmd_value           (cmd_value),
  .status_sel          (status_sel),
  .status_word         (status_word),
  .short_chirp_cycles  (short_chirp_cycles),
  .medium_chirp_cycles (medium_chirp_cycles),
  .thresh_scale        (thresh_scale),
  .adc_powerdown       (adc_powerdown),
  .adc_twos_comp       (adc_twos_comp),
  .chirp_count_err     (chirp_count_err),
  .unknown_opcode      (unknown_opcode),
  .wr_en               (wr_en)
);

// File: tb/radar_cmd_decoder_tb_top.sv
module radar_cmd_decoder_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int N_VEC = 14;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [7:0]  cmd_opcode = '0;
  logic [15:0] cmd_value = '0;
  logic [2:0]  status_sel = '0;
  logic [31:0] status_word;
  logic [15:0] short_chirp_cycles, short_listen_cycles;
  logic [15:0] medium_chirp_cycles, medium_listen_cycles;
  logic [7:0]  thresh_scale;
  logic        adc_powerdown, adc_twos_comp;
  logic [7:0]  chirps_per_elev;
  logic        chirp_count_err, unknown_opcode;

  int n_checks = 0;
  int n_fail = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  radar_cmd_decoder dut_i (
    .clk (clk), .rst_n (rst_n), .cmd_valid (cmd_valid),
    .cmd_opcode (cmd_opcode), .cmd_value (cmd_value),
    .status_sel (status_sel), .status_word (status_word),
    .short_chirp_cycles (short_chirp_cycles),
    .short_listen_cycles (short_listen_cycles),
    .medium_chirp_cycles (medium_chirp_cycles),
    .medium_listen_cycles (medium_listen_cycles),
    .thresh_scale (thresh_scale), .adc_powerdown (adc_powerdown),
    .adc_twos_comp (adc_twos_comp), .chirps_per_elev (chirps_per_elev),
    .chirp_count_err (chirp_count_err), .unknown_opcode (unknown_opcode)
  );

  // Vector: opcode[43:36], value[35:20], observed output id[19:16], expected[15:0]
  localparam logic [43:0] VEC [N_VEC] = '{
    {8'h10, 16'd1234,  4'd0, 16'd1234},
    {8'h11, 16'hABCD,  4'd1, 16'hABCD},
    {8'h17, 16'h0321,  4'd2, 16'h0321},
    {8'h18, 16'hFFFF,  4'd3, 16'hFFFF},
    {8'h2D, 16'hA53C,  4'd4, 16'h003C},
    {8'h32, 16'h0001,  4'd5, 16'd1},
    {8'h32, 16'hFFFE,  4'd5, 16'd0},
    {8'h33, 16'h8001,  4'd6, 16'd1},
    {8'h21, 16'd48,    4'd8, 16'd0},
    {8'h21, 16'd48,    4'd7, 16'd48},
    {8'h44, 16'h1234,  4'd9, 16'd1},
    {8'h21, 16'd7,     4'd7, 16'd48},
    {8'h21, 16'd7,     4'd8, 16'd1},
    {8'h21, 16'd48,    4'd8, 16'd1}
  };

  function automatic logic [15:0] observe(input logic [3:0] id);
    case (id)
      4'd0: return short_chirp_cycles;
      4'd1: return short_listen_cycles;
      4'd2: return medium_chirp_cycles;
      4'd3: return medium_listen_cycles;
      4'd4: return {8'd0, thresh_scale};
      4'd5: return {15'd0, adc_powerdown};
      4'd6: return {15'd0, adc_twos_comp};
      4'd7: return {8'd0, chirps_per_elev};
      4'd8: return {15'd0, chirp_count_err};
      default: return {15'd0, unknown_opcode};
    endcase
  endfunction

  function automatic string req_of(input logic [3:0] id);
    case (id)
      4'd0, 4'd1, 4'd2, 4'd3: return "R2";
      4'd4: return "R3";
      4'd5: return "R4";
      4'd6: return "R5";
      4'd7: return "R6";
      4'd8: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Drive on falling edge; load happens at the next rising edge; sample on the falling edge after it.
  task automatic send(input logic [7:0] op, input logic [15:0] val);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_opcode = op; cmd_value = val;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic check_defaults(input string tag);
    check("R1", {tag, " short chirp"},  {16'd0, short_chirp_cycles}, 32'd100);
    check("R1", {tag, " short listen"}, {16'd0, short_listen_cycles}, 32'd17400);
    check("R1", {tag, " medium chirp"}, {16'd0, medium_chirp_cycles}, 32'd500);
    check("R1", {tag, " medium listen"},{16'd0, medium_listen_cycles}, 32'd15600);
    check("R1", {tag, " thresh"},       {24'd0, thresh_scale}, 32'h18);
    check("R1", {tag, " pins"},         {30'd0, adc_twos_comp, adc_powerdown}, 32'd0);
    check("R1", {tag, " cpe"},          {24'd0, chirps_per_elev}, 32'd48);
    check("R1", {tag, " flags"},        {30'd0, chirp_count_err, unknown_opcode}, 32'd0);
  endtask

  initial begin
    do_reset();
    check_defaults("reset");

    for (int i = 0; i < N_VEC; i++) begin
      send(VEC[i][43:36], VEC[i][35:20]);
      check(req_of(VEC[i][19:16]), $sformatf("vector %0d", i),
            {16'd0, observe(VEC[i][19:16])}, {16'd0, VEC[i][15:0]});
    end

    // R8: unknown opcode leaves every register alone, pulse lasts one cycle.
    send(8'hFF, 16'h0000);
    check("R8", "pulse on unknown", {31'd0, unknown_opcode}, 32'd1);
    check("R8", "short chirp kept", {16'd0, short_chirp_cycles}, 32'd1234);
    check("R8", "medium listen kept", {16'd0, medium_listen_cycles}, 32'hFFFF);
    check("R8", "thresh kept", {24'd0, thresh_scale}, 32'h3C);
    @(negedge clk);
    check("R8", "pulse ends", {31'd0, unknown_opcode}, 32'd0);

    // R9: activity on opcode/value with valid low changes nothing.
    @(negedge clk);
    cmd_opcode = 8'h10; cmd_value = 16'd9;
    @(negedge clk);
    cmd_opcode = 8'h32; cmd_value = 16'd1;
    @(negedge clk);
    cmd_opcode = 8'h77;
    @(negedge clk);
    check("R9", "short chirp held", {16'd0, short_chirp_cycles}, 32'd1234);
    check("R9", "powerdown held", {31'd0, adc_powerdown}, 32'd0);
    check("R9", "no unknown pulse", {31'd0, unknown_opcode}, 32'd0);

    // R10: status words.
    send(8'h21, 16'd99);
    send(8'h32, 16'd1);
    status_sel = 3'd0; #1;
    check("R10", "word0", status_word, {16'd1234, 16'hABCD});
    status_sel = 3'd1; #1;
    check("R10", "word1", status_word, 32'h3C00_0003);
    status_sel = 3'd2; #1;
    check("R10", "word2", status_word, 32'd99);
    status_sel = 3'd3; #1;
    check("R10", "word3", status_word, 32'd0);
    status_sel = 3'd4; #1;
    check("R10", "word4", status_word, 32'h0000_0430);
    status_sel = 3'd6; #1;
    check("R10", "word6", status_word, 32'd0);
    status_sel = 3'd7; #1;
    check("R10", "select 7", status_word, 32'd0);

    // R7: only reset clears the sticky error; R1 defaults return.
    do_reset();
    check("R7", "err cleared by reset", {31'd0, chirp_count_err}, 32'd0);
    check_defaults("second reset");
    status_sel = 3'd4; #1;
    check("R10", "word4 after reset", status_word, 32'h0000_0030);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule